// File: doc/BRIEF.md
# Power-Good and Voltage Fault Supervisor

This block supervises the output-voltage status of one regulator channel. Digital comparator flags come in from the analog side: start-up complete, sense voltage below or above the regulation window, output undervoltage, output overvoltage and an overcurrent trip. From these flags the block derives four outputs. The first is a power-good signal; high means the open-drain pin is released and low means it is pulled down. The other three are a latched undervoltage indication, a request to switch the channel off, and a command that forces the synchronous lower gate on.

Window violations pass through a deglitch counter before power-good drops, so short disturbances during load steps are ignored. An undervoltage flag latches the channel off at once. An overcurrent trip is held by the same kind of latch. Both latches clear only when both enables are low together, or on power-on reset. An overvoltage acts as a crowbar that does not latch: the lower gate is forced on and power-good is pulled low, and both return to normal as soon as the flag clears. While the crowbar is active it takes priority over the channel-off request.

Top module: `pgood_supervisor`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `pgood`, `uv_latched`, `chan_off` and `lgate_force` are all 0, and the deglitch count is zero.
- R2: `pgood` is 0 on every clock edge where `ss_done` was sampled low.
- R3: With `ss_done` high, both window flags low, and no overvoltage or set latch, `pgood` goes to 1 on the next clock edge.
- R4: `pgood` falls on the clock edge after the window violation (`win_lo` or `win_hi`) has been sampled on FILT_CYCLES consecutive edges. A violation that lasts fewer edges leaves `pgood` high.
- R5: A single edge with both window flags low restarts the violation count from zero.
- R6: `uv_flag` sampled high sets `uv_latched` on that same edge, with no filter. On that edge `pgood` goes to 0 and `chan_off` goes to 1 (unless the crowbar is active).
- R7: The undervoltage latch stays set after `uv_flag` clears and while either enable is high. It clears on the edge where both `en_a` and `en_b` are sampled low.
- R8: `oc_trip` sampled high sets an internal overcurrent latch. That latch holds `pgood` low and raises `chan_off`, and it clears under the same rule as R7.
- R9: `ov_flag` sampled high gives `lgate_force` = 1 and `pgood` = 0 on the next edge. Both follow the flag back on the first edge after it clears, with no latching.
- R10: While `lgate_force` is 1, `chan_off` is 0, even if a latch is set.
- R11: When both enables are sampled low, the clear wins over a fault flag sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ss_done | input | 1 | Soft-start has reached its completion level |
| win_lo | input | 1 | Sense voltage below the power-good window |
| win_hi | input | 1 | Sense voltage above the power-good window |
| uv_flag | input | 1 | Output below the undervoltage threshold |
| ov_flag | input | 1 | Output above the overvoltage threshold |
| oc_trip | input | 1 | Overcurrent protection has tripped |
| en_a | input | 1 | First enable |
| en_b | input | 1 | Second enable |
| pgood | output | 1 | Power-good; 1 = released, 0 = pulled low |
| uv_latched | output | 1 | Undervoltage latch state |
| chan_off | output | 1 | Request to disable the channel |
| lgate_force | output | 1 | Force the lower gate on (crowbar) |

## Verification
The bench drives window violations that last exactly one edge short of the filter length. It also breaks long violations with a single in-window sample. A design that miscounts or does not restart the count would drop power-good too early, or would never drop it. Undervoltage and overcurrent faults are followed by clearing with only one enable low, then with both low, and then with a fault flag present during the clear. These steps expose latches that clear too easily or that re-arm over the clear. An overvoltage is raised both on its own and together with a set latch, which shows whether the crowbar releases at once and whether it masks the channel-off request.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

  // Index of each fault kept by the supervisor latches.
  typedef enum int unsigned {
    FLT_UV = 0,
    FLT_OC = 1
  } fault_idx_e;

  localparam int unsigned NUM_FAULTS = 2;

  // Latches are cleared only when the channel is fully disabled.
  function automatic logic both_disabled(input logic a, input logic b);
    return !a && !b;
  endfunction

  // The window is violated if the sense voltage is outside on either side.
  function automatic logic window_violated(input logic lo, input logic hi);
    return lo || hi;
  endfunction

  // Power-good is released only when every condition is healthy.
  function automatic logic pg_release(input logic started,
                                      input logic filtered_bad,
                                      input logic crowbar,
                                      input logic any_latch);
    return started && !filtered_bad && !crowbar && !any_latch;
  endfunction

endpackage

// File: rtl/pgs_window_filter.sv
module pgs_window_filter #(
  parameter int unsigned FILT_CYCLES = 600
) (
  input  logic                               clk,
  input  logic                               por_n,
  input  logic                               viol,
  output logic [$clog2(FILT_CYCLES+1)-1:0]   viol_count,
  output logic                               win_bad
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == LIMIT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q <= '0;
    end else if (!viol) begin
      cnt_q <= '0;
    end else if (!at_limit) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign viol_count = cnt_q;
  assign win_bad    = at_limit;

endmodule

// File: rtl/pgs_fault_latch.sv
module pgs_fault_latch (
  input  logic clk,
  input  logic por_n,
  input  logic set_in,
  input  logic clr_in,
  output logic q,
  output logic q_next
);
  logic q_r;

  // Clear outranks set.
  always_comb begin
    if (clr_in)       q_next = 1'b0;
    else if (set_in)  q_next = 1'b1;
    else              q_next = q_r;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) q_r <= 1'b0;
    else        q_r <= q_next;
  end

  assign q = q_r;

endmodule

// File: rtl/pgs_output_stage.sv
module pgs_output_stage
  import pgs_pkg::*;
(
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  ss_done,
  input  logic                  win_bad,
  input  logic                  ov_flag,
  input  logic [NUM_FAULTS-1:0] latch_next,
  input  logic [NUM_FAULTS-1:0] latch_q,
  output logic                  pgood,
  output logic                  lgate_force,
  output logic                  chan_off
);
  logic pg_r;
  logic lg_r;
  logic pg_d;

  assign pg_d = pg_release(ss_done, win_bad, ov_flag, |latch_next);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pg_r <= 1'b0;
      lg_r <= 1'b0;
    end else begin
      pg_r <= pg_d;
      lg_r <= ov_flag;
    end
  end

  assign pgood       = pg_r;
  assign lgate_force = lg_r;
  // The crowbar keeps the driver alive even when a latch wants the channel off.
  assign chan_off    = (|latch_q) && !lg_r;

endmodule

// File: rtl/pgood_supervisor.sv
module pgood_supervisor
  import pgs_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 600
) (
  input  logic clk,
  input  logic por_n,
  input  logic ss_done,
  input  logic win_lo,
  input  logic win_hi,
  input  logic uv_flag,
  input  logic ov_flag,
  input  logic oc_trip,
  input  logic en_a,
  input  logic en_b,
  output logic pgood,
  output logic uv_latched,
  output logic chan_off,
  output logic lgate_force
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  // Named internal events, also observed by the checker.
  logic                  win_viol;
  logic                  win_bad;
  logic [CW-1:0]         viol_count;
  logic                  clear_req;
  logic [NUM_FAULTS-1:0] fault_set;
  logic [NUM_FAULTS-1:0] latch_q;
  logic [NUM_FAULTS-1:0] latch_next;

  assign win_viol  = window_violated(win_lo, win_hi);
  assign clear_req = both_disabled(en_a, en_b);

  assign fault_set[FLT_UV] = uv_flag;
  assign fault_set[FLT_OC] = oc_trip;

  pgs_window_filter #(
    .FILT_CYCLES(FILT_CYCLES)
  ) u_filter (
    .clk       (clk),
    .por_n     (por_n),
    .viol      (win_viol),
    .viol_count(viol_count),
    .win_bad   (win_bad)
  );

  for (genvar g = 0; g < NUM_FAULTS; g++) begin : g_latch
    pgs_fault_latch u_latch (
      .clk   (clk),
      .por_n (por_n),
      .set_in(fault_set[g]),
      .clr_in(clear_req),
      .q     (latch_q[g]),
      .q_next(latch_next[g])
    );
  end

  pgs_output_stage u_out (
    .clk        (clk),
    .por_n      (por_n),
    .ss_done    (ss_done),
    .win_bad    (win_bad),
    .ov_flag    (ov_flag),
    .latch_next (latch_next),
    .latch_q    (latch_q),
    .pgood      (pgood),
    .lgate_force(lgate_force),
    .chan_off   (chan_off)
  );

  assign uv_latched = latch_q[FLT_UV];

endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int unsigned CW = 10
) (
  input logic          clk,
  input logic          por_n,
  input logic          ss_done,
  input logic          win_lo,
  input logic          win_hi,
  input logic          uv_flag,
  input logic          ov_flag,
  input logic          oc_trip,
  input logic          en_a,
  input logic          en_b,
  input logic          pgood,
  input logic          uv_latched,
  input logic          chan_off,
  input logic          lgate_force,
  input logic [CW-1:0] viol_count,
  input logic [1:0]    latch_q
);

  p_ss_gate_r2: assert property (@(posedge clk) disable iff (!por_n)
    !ss_done |=> !pgood);

  p_in_window_restart_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!win_lo && !win_hi) |=> (viol_count == '0));

  p_uv_set_r6: assert property (@(posedge clk) disable iff (!por_n)
    (uv_flag && (en_a || en_b)) |=> (uv_latched && !pgood));

  p_uv_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (uv_latched && (en_a || en_b)) |=> uv_latched);

  p_latch_holds_pg_r8: assert property (@(posedge clk) disable iff (!por_n)
    (|latch_q) |-> !pgood);

  p_ov_force_r9: assert property (@(posedge clk) disable iff (!por_n)
    ov_flag |=> (lgate_force && !pgood));

  p_ov_release_r9: assert property (@(posedge clk) disable iff (!por_n)
    !ov_flag |=> !lgate_force);

  p_crowbar_priority_r10: assert property (@(posedge clk) disable iff (!por_n)
    ov_flag |=> !chan_off);

  p_clear_wins_r11: assert property (@(posedge clk) disable iff (!por_n)
    (!en_a && !en_b) |=> (latch_q == 2'b00));

endmodule

bind pgood_supervisor pgs_checker #(
  .CW($clog2(FILT_CYCLES + 1))
) u_pgs_checker (
  .clk        (clk),
  .por_n      (por_n),
  .ss_done    (ss_done),
  .win_lo     (win_lo),
  .win_hi     (win_hi),
  .uv_flag    (uv_flag),
  .ov_flag    (ov_flag),
  .oc_trip    (oc_trip),
  .en_a       (en_a),
  .en_b       (en_b),
  .pgood      (pgood),
  .uv_latched (uv_latched),
  .chan_off   (chan_off),
  .lgate_force(lgate_force),
  .viol_count (viol_count),
  .latch_q    (latch_q)
);

// File: tb/pgood_supervisor_test.sv
`timescale 1ns/1ps
module pgood_supervisor_test;
  localparam int FILT = 600;

  logic clk = 1'b0;
  logic por_n, ss_done, win_lo, win_hi, uv_flag, ov_flag, oc_trip, en_a, en_b;
  logic pgood, uv_latched, chan_off, lgate_force;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Behavioural reference state.
  int m_run;
  bit m_pg, m_uv, m_oc, m_lg;
  string tag;

  always #2.5 clk = ~clk;

  pgood_supervisor #(.FILT_CYCLES(FILT)) uut (
    .clk(clk), .por_n(por_n), .ss_done(ss_done), .win_lo(win_lo),
    .win_hi(win_hi), .uv_flag(uv_flag), .ov_flag(ov_flag), .oc_trip(oc_trip),
    .en_a(en_a), .en_b(en_b), .pgood(pgood), .uv_latched(uv_latched),
    .chan_off(chan_off), .lgate_force(lgate_force)
  );

  task automatic check1(input string name, input logic act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, name, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check1("pgood", pgood, m_pg);
    check1("uv_latched", uv_latched, m_uv);
    check1("chan_off", chan_off, (m_uv || m_oc) && !m_lg);
    check1("lgate_force", lgate_force, m_lg);
  endtask

  // One clock: model advances on the rising edge, compare on the falling edge.
  task automatic step();
    bit clr;
    @(posedge clk);
    if (!por_n) begin
      m_run = 0; m_pg = 0; m_uv = 0; m_oc = 0; m_lg = 0;
    end else begin
      clr = !en_a && !en_b;
      m_uv = clr ? 1'b0 : (m_uv || uv_flag);
      m_oc = clr ? 1'b0 : (m_oc || oc_trip);
      m_pg = ss_done && (m_run < FILT) && !ov_flag && !m_uv && !m_oc;
      m_lg = ov_flag;
      if (win_lo || win_hi) m_run = (m_run < FILT) ? m_run + 1 : FILT;
      else m_run = 0;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    por_n = 1'b0;
    m_run = 0; m_pg = 0; m_uv = 0; m_oc = 0; m_lg = 0;
    #1;
    tag = "R1";
    compare_all();
    run(3);
    por_n = 1'b1;
    run(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; ss_done = 0; win_lo = 0; win_hi = 0; uv_flag = 0;
    ov_flag = 0; oc_trip = 0; en_a = 1; en_b = 1;
    @(negedge clk);
    do_reset();

    tag = "R2"; run(5);
    win_lo = 1; run(3); win_lo = 0; run(2);

    tag = "R3"; ss_done = 1; run(4);
    check1("pgood high R3", pgood, 1'b1);

    tag = "R4"; win_lo = 1; run(FILT - 1); win_lo = 0; run(2);
    check1("pgood kept after short violation R4", pgood, 1'b1);

    tag = "R5"; win_hi = 1; run(FILT - 2); win_hi = 0; run(1);
    win_hi = 1; run(FILT - 1); win_hi = 0; run(2);
    check1("pgood kept after restart R5", pgood, 1'b1);

    tag = "R4"; win_hi = 1; run(FILT + 1);
    check1("pgood dropped after full window R4", pgood, 1'b0);
    run(5); win_hi = 0; run(3);

    tag = "R9"; ov_flag = 1; run(1);
    check1("lgate_force on R9", lgate_force, 1'b1);
    run(3); ov_flag = 0; run(1);
    check1("lgate_force off R9", lgate_force, 1'b0);
    run(2);

    tag = "R6"; uv_flag = 1; run(1);
    check1("uv latched at once R6", uv_latched, 1'b1);
    uv_flag = 0; run(4);
    tag = "R7"; en_a = 0; run(3);
    check1("uv held with one enable R7", uv_latched, 1'b1);
    en_b = 0; run(1);
    check1("uv cleared by both low R7", uv_latched, 1'b0);
    tag = "R11"; uv_flag = 1; oc_trip = 1; run(3);
    check1("clear beats set R11", uv_latched, 1'b0);
    uv_flag = 0; oc_trip = 0; en_a = 1; en_b = 1; run(3);

    tag = "R8"; oc_trip = 1; run(1); oc_trip = 0; run(3);
    check1("oc holds chan_off R8", chan_off, 1'b1);
    tag = "R10"; ov_flag = 1; run(3);
    check1("crowbar masks chan_off R10", chan_off, 1'b0);
    ov_flag = 0; run(2);
    tag = "R8"; en_b = 0; run(2); en_a = 0; run(1); en_a = 1; en_b = 1; run(3);
    check1("pgood back after oc clear R8", pgood, 1'b1);

    tag = "R10"; uv_flag = 1; ov_flag = 1; run(1); uv_flag = 0; run(2);
    ov_flag = 0; run(2);

    tag = "R1"; do_reset(); run(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule